// File: doc/BRIEF.md
# Vector element step sequencer

This block walks a single vector instruction through its elements. The source and destination sides each keep an element index and a sub-element index. The sub-element index is the inner loop. While the loop runs, the block asks fetch to hold the program counter so that the same instruction issues again with fresh indices. Each time the execution side strobes that an instruction has completed, the block moves both sides forward, skipping elements that the predicate masks switch off. It releases the program counter as soon as either side has delivered its last sub-element.

Each side can be set to zeroing. In that case masked-out elements are not skipped. They are visited in order, and the block flags that the element must be written or read as zero. A vector length of zero, or a mask that leaves no active element before the vector length, ends the loop at once. An instruction that is not in vector mode passes straight through.

Top module: `vstep_seq`

## Requirements
- R1: A synchronous reset sets all four indices (source element, source sub-element, destination element, destination sub-element) to 0. Without a `done` strobe the indices keep their values.
- R2: The sub-element index counts 0, 1, … up to `subvl` inclusive. When a `done` strobe arrives with the sub-element index equal to `subvl`, the sub-element index returns to 0 and the element index moves to the next element.
- R3: The source and destination sides advance independently, each under its own mask and zeroing flag.
- R4: When a side's sub-element index is 0 and its zeroing flag is clear, the presented element index is the lowest index at or above the stored index whose mask bit is 1. The search stops at `vl`. Mask bit n belongs to element n, and elements at 64 or above count as masked off. When the sub-element index is not 0, no skipping happens.
- R5: When a side's zeroing flag is set, that side does no skipping. Its zeroing output is 1 exactly when the mask bit at the current element is 0 and vector mode is on.
- R6: `loop_end` is 1 when either side is at element `vl`-1 with its sub-element index equal to `subvl`.
- R7: `hold_pc` is the inverse of `loop_end`. While it is 1, each `done` strobe advances the indices.
- R8: A `done` strobe with `loop_end` at 1 returns all four indices to 0. When `vec_en` is 0, `loop_end` is always 1.
- R9: With `vec_en` at 1 and `vl` equal to 0, `loop_end` is 1 and `hold_pc` is 0 from the first cycle.
- R10: If skipping on either side reaches `vl`, so that no active element remains, `loop_end` is 1 and no element is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst | input | 1 | synchronous reset, active high |
| vl | input | 7 | vector length |
| subvl | input | 2 | last sub-element index (group size minus 1) |
| vec_en | input | 1 | instruction runs in vector mode |
| src_mask | input | 64 | source predicate, bit n for element n |
| dst_mask | input | 64 | destination predicate, bit n for element n |
| src_zero | input | 1 | zeroing on the source side |
| dst_zero | input | 1 | zeroing on the destination side |
| done | input | 1 | current element finished, advance on this edge |
| src_step | output | 7 | source element index, after skipping |
| src_sub | output | 2 | source sub-element index |
| dst_step | output | 7 | destination element index, after skipping |
| dst_sub | output | 2 | destination sub-element index |
| src_zeroing | output | 1 | source element is masked and must read as zero |
| dst_zeroing | output | 1 | destination element is masked and must be written as zero |
| hold_pc | output | 1 | repeat the current instruction |
| loop_end | output | 1 | last element of this instruction, or nothing to issue |

## Verification
A corrupted index shows up on `src_step`, `dst_step` or the sub-element outputs in the cycle right after the `done` strobe that produced it. A wrong skip shows up at once as a presented index that differs from the lowest set mask bit. A wrong end test shows up as `hold_pc` releasing early, which drops elements, or late, which runs a sub-element past `subvl`. Both are visible within one strobe of the true last element. The sweep covers every sub-group size with several short vector lengths, sparse and empty masks, and both zeroing settings. It also toggles the source mask on every strobe, so that any skip taken in the middle of a group is caught.

// File: rtl/vstep_seq.sv
`timescale 1ns/1ps
module vstep_seq #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STEP_W-1:0] vl,
  input  logic [SUB_W-1:0]  subvl,
  input  logic              vec_en,
  input  logic [MASK_W-1:0] src_mask,
  input  logic [MASK_W-1:0] dst_mask,
  input  logic              src_zero,
  input  logic              dst_zero,
  input  logic              done,
  output logic [STEP_W-1:0] src_step,
  output logic [SUB_W-1:0]  src_sub,
  output logic [STEP_W-1:0] dst_step,
  output logic [SUB_W-1:0]  dst_sub,
  output logic              src_zeroing,
  output logic              dst_zeroing,
  output logic              hold_pc,
  output logic              loop_end
);
  localparam int IW = $clog2(MASK_W);

  logic [STEP_W-1:0] s_step_q, d_step_q;
  logic [SUB_W-1:0]  s_sub_q, d_sub_q;
  logic [STEP_W-1:0] vl_m1;
  logic src_fin, dst_fin, exhausted;

  function automatic logic mbit(input logic [MASK_W-1:0] m, input logic [STEP_W-1:0] i);
    mbit = (int'(i) < MASK_W) ? m[i[IW-1:0]] : 1'b0;
  endfunction

  function automatic logic [STEP_W-1:0] first_active(input logic [MASK_W-1:0] m,
      input logic [STEP_W-1:0] start, input logic [STEP_W-1:0] lim);
    logic hit;
    first_active = lim;
    hit = 1'b0;
    for (int k = 0; k < MASK_W; k++)
      if (!hit && int'(start) <= k && k < int'(lim) && m[k]) begin
        first_active = STEP_W'(k);
        hit = 1'b1;
      end
  endfunction

  assign src_step = (s_sub_q == '0 && !src_zero) ? first_active(src_mask, s_step_q, vl) : s_step_q;
  assign dst_step = (d_sub_q == '0 && !dst_zero) ? first_active(dst_mask, d_step_q, vl) : d_step_q;
  assign src_sub  = s_sub_q;
  assign dst_sub  = d_sub_q;

  assign src_zeroing = vec_en && src_zero && !mbit(src_mask, s_step_q);
  assign dst_zeroing = vec_en && dst_zero && !mbit(dst_mask, d_step_q);

  assign vl_m1     = vl - STEP_W'(1);
  assign exhausted = (src_step == vl) || (dst_step == vl);
  assign src_fin   = (src_step == vl_m1) && (s_sub_q == subvl);
  assign dst_fin   = (dst_step == vl_m1) && (d_sub_q == subvl);
  assign loop_end  = !vec_en || exhausted || src_fin || dst_fin;
  assign hold_pc   = !loop_end;

  always_ff @(posedge clk) begin
    if (rst || (done && loop_end)) begin
      s_step_q <= '0;
      d_step_q <= '0;
      s_sub_q  <= '0;
      d_sub_q  <= '0;
    end else if (done) begin
      if (s_sub_q == subvl) begin
        s_step_q <= (src_step == vl_m1) ? src_step : src_step + STEP_W'(1);
        s_sub_q  <= '0;
      end else begin
        s_step_q <= src_step;
        s_sub_q  <= s_sub_q + SUB_W'(1);
      end
      if (d_sub_q == subvl) begin
        d_step_q <= (dst_step == vl_m1) ? dst_step : dst_step + STEP_W'(1);
        d_sub_q  <= '0;
      end else begin
        d_step_q <= dst_step;
        d_sub_q  <= d_sub_q + SUB_W'(1);
      end
    end
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(s_step_q) && $stable(s_sub_q) && $stable(d_step_q) && $stable(d_sub_q)));

  // R2
  sub_count_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !loop_end && s_sub_q != subvl) |=> (s_sub_q == $past(s_sub_q) + SUB_W'(1)));

  // R5
  zero_no_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (src_zero && s_sub_q == '0) |-> (src_step == s_step_q));

  // R8
  end_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && loop_end) |=> (s_step_q == '0 && d_step_q == '0 && s_sub_q == '0 && d_sub_q == '0));

  // R10
  no_active_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_en && (src_step == vl || dst_step == vl)) |-> loop_end);
endmodule

// File: tb/vstep_seq_test.sv
`timescale 1ns/1ps
module vstep_seq_test;
  logic clk = 0, rst = 1;
  logic [6:0] vl = 0;
  logic [1:0] subvl = 0;
  logic vec_en = 0, src_zero = 0, dst_zero = 0, done = 0;
  logic [63:0] src_mask = 0, dst_mask = 0;
  logic [6:0] src_step, dst_step;
  logic [1:0] src_sub, dst_sub;
  logic src_zeroing, dst_zeroing, hold_pc, loop_end;

  int checks = 0, fails = 0;
  int ms = 0, md = 0, mss = 0, mds = 0;
  bit summary_done = 0;

  always #2.5 clk = ~clk;

  vstep_seq uut (.clk, .rst, .vl, .subvl, .vec_en, .src_mask, .dst_mask,
    .src_zero, .dst_zero, .done, .src_step, .src_sub, .dst_step, .dst_sub,
    .src_zeroing, .dst_zeroing, .hold_pc, .loop_end);

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int next_on(input logic [63:0] m, input int start, input int lim);
    int i = start;
    while (i < lim && !(i < 64 && m[i])) i++;
    return i;
  endfunction

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
    $finish;
  endtask

  // one strobe: compare against the model, then advance the model
  task automatic step_once(input string tag, output bit ended);
    int es, ed, n;
    bit ex, zs, zd;
    done = 1;
    #1;
    n = vl;
    es = (mss == 0 && !src_zero) ? next_on(src_mask, ms, n) : ms;
    ed = (mds == 0 && !dst_zero) ? next_on(dst_mask, md, n) : md;
    ex = !vec_en || es == n || ed == n || (es == n - 1 && mss == subvl) || (ed == n - 1 && mds == subvl);
    zs = vec_en && src_zero && !(ms < 64 && src_mask[ms]);
    zd = vec_en && dst_zero && !(md < 64 && dst_mask[md]);
    chk({tag, "/R4 R3"}, "src_step", src_step, es);
    chk({tag, "/R4 R3"}, "dst_step", dst_step, ed);
    chk({tag, "/R2"}, "src_sub", src_sub, mss);
    chk({tag, "/R2"}, "dst_sub", dst_sub, mds);
    chk({tag, "/R5"}, "src_zeroing", src_zeroing, zs);
    chk({tag, "/R5"}, "dst_zeroing", dst_zeroing, zd);
    chk({tag, "/R6 R10"}, "loop_end", loop_end, ex);
    chk({tag, "/R7"}, "hold_pc", hold_pc, !ex);
    if (ex) begin
      ms = 0; md = 0; mss = 0; mds = 0;
    end else begin
      if (mss == subvl) begin ms = (es == n - 1) ? es : es + 1; mss = 0; end
      else begin ms = es; mss++; end
      if (mds == subvl) begin md = (ed == n - 1) ? ed : ed + 1; mds = 0; end
      else begin md = ed; mds++; end
    end
    ended = ex;
  endtask

  task automatic run(input string tag, input int v, input int sv, input bit ve,
      input logic [63:0] sm, input logic [63:0] dm, input bit sz, input bit dz, input bit flip);
    bit ended;
    for (int it = 0; it < 80; it++) begin
      @(negedge clk);
      vl = 7'(v); subvl = 2'(sv); vec_en = ve;
      src_mask = (flip && it[0]) ? ~sm : sm;
      dst_mask = dm; src_zero = sz; dst_zero = dz;
      step_once(tag, ended);
      if (ended) break;
    end
    @(negedge clk);
    done = 0;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] pats [4];
    int vls [4];
    bit ended;
    pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[1] = 64'h0;
    pats[2] = 64'h5555_5555_5555_5555;
    pats[3] = 64'h0000_0000_0000_0024;
    vls[0] = 0; vls[1] = 1; vls[2] = 3; vls[3] = 6;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1", "src_sub after reset", src_sub, 0);
    chk("R1", "dst_sub after reset", dst_sub, 0);
    chk("R8", "loop_end non-vector", loop_end, 1);

    // R9: zero length in vector mode ends immediately
    @(negedge clk);
    vl = 0; vec_en = 1; src_mask = '1; dst_mask = '1;
    #1;
    chk("R9", "loop_end vl0", loop_end, 1);
    chk("R9", "hold_pc vl0", hold_pc, 0);

    // R10: empty source mask means nothing to issue
    @(negedge clk);
    vl = 5; src_mask = 0;
    #1;
    chk("R10", "loop_end empty mask", loop_end, 1);
    chk("R10", "src_step empty mask", src_step, 5);

    // R1 / R7: partial run, then idle cycles must not move the indices
    @(negedge clk);
    vl = 6; subvl = 1; src_mask = '1; dst_mask = 64'h0000_0000_0000_0030;
    step_once("R7", ended);
    @(negedge clk);
    step_once("R7", ended);
    @(negedge clk);
    done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", "src_step held", src_step, 1);
    chk("R1", "src_sub held", src_sub, 0);
    chk("R3", "dst_step independent", dst_step, 5);
    chk("R7", "hold_pc running", hold_pc, 1);
    run("R6", 6, 1, 1, '1, 64'h0000_0000_0000_0030, 0, 0, 0);

    // sweep
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++)
          for (int q = 0; q < 4; q++)
            for (int z = 0; z < 4; z++)
              for (int f = 0; f < 2; f++)
                run("sweep", vls[a], s, 1, pats[p], pats[q], z[0], z[1], f[0]);

    // R8: non-vector passes through, and the next run starts from zero
    run("R8", 4, 2, 0, '1, '1, 0, 0, 0);
    run("R8", 4, 2, 1, '1, '1, 0, 0, 0);
    summary();
  end
endmodule